// File: doc/BRIEF.md
# Change-Triggered Interrupt Request Controller

This block watches a vector of internal status bits and turns any change of value, rising or falling, into a latched per-bit event flag. Software reads the flags, clears the ones it has handled by writing ones to them, and picks which events reach each of two interrupt request lines through two independent enable masks. Each line has its own enable and its own active level. A disabled line or a line with no pending event sits at its inactive level.

The second request line has no dedicated pin. It can be routed onto one of three shared output pins, where it replaces that pin's normal function. Pins that are not selected carry their normal function unchanged. Access is through a simple synchronous register port. Writes take effect at the clock edge. Reads are combinational from the register state.

Register map (address, content):

- 0: event flags. Read returns the flags. Writing a one clears that bit; writing a zero has no effect.
- 1: line-1 enable mask.
- 2: line-2 enable mask.
- 3: configuration, zero-extended on read. Bit 0 enables line 1 and bit 1 sets its level (1 = active-high). Bit 2 enables line 2 and bit 3 sets its level. Bits 5:4 route line 2 (0 = none, 1/2/3 = pin 0/1/2).

The vector width `N` must be at least 6.

Top module: `irq_change_ctrl`

## Requirements
- R1: After reset, the flags, both masks and the configuration read as zero. `int1_o` is 1, the inactive level of an active-low line, and `pin_o` equals `pin_func_i`.
- R2: A change in either direction of `status_i[i]` between two consecutive clock edges sets flag i at the second edge. The value `status_i` holds across reset sets no flag.
- R3: A write to address 0 clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: If bit i changes in the same cycle that a write to address 0 clears flag i, flag i stays set.
- R5: When enabled (config bit 0 = 1), line 1 is active exactly when some flag is set whose line-1 mask bit (address 1) is 1.
- R6: When enabled (config bit 2 = 1), line 2 is active exactly when some flag is set whose line-2 mask bit (address 2) is 1. This is independent of the line-1 mask.
- R7: A level bit of 1 makes a line drive 1 when active and 0 when inactive. A level bit of 0 inverts both.
- R8: A line whose enable bit is 0 drives its inactive level, whatever the flags hold.
- R9: With route value r in 1..3, `pin_o[r-1]` carries line 2 and every other pin equals its `pin_func_i` bit. With r = 0, all pins equal `pin_func_i`.
- R10: Addresses 1 and 2 read back the last value written. Address 3 reads back bits 5:0 of the last value written, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| status_i | input | N | Status bits to watch |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | N | Register write data |
| reg_rdata | output | N | Register read data |
| int1_o | output | 1 | Interrupt request line 1 |
| pin_func_i | input | 3 | Normal function of the three shared pins |
| pin_o | output | 3 | Shared pins after routing of line 2 |

## Verification
The bench toggles every status bit in both directions. A design that detects only one edge, or drops the previous-value register, would miss half of these toggles. It holds nonzero status through reset to catch a design that raises flags from the reset value of its history register.

It clears one flag in the same cycle that its bit toggles again. A controller that gives the clear priority would lose that event.

It sweeps every enable and level combination of both lines against several flag and mask patterns, and every route value against every pin pattern. A swapped mask, an inverted level, a disabled line left active, or a mux that disturbs unselected pins would each show up at the ports.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CFG_W  = 6;
  localparam int NPINS  = 3;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_FLAGS = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK1 = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK2 = 2'd2;
  localparam logic [ADDR_W-1:0] A_CFG   = 2'd3;

  typedef struct packed {
    logic [1:0] route;
    logic       lvl2;
    logic       en2;
    logic       lvl1;
    logic       en1;
  } cfg_t;

  // Pin level from an active indication and a level bit (1 = active-high).
  function automatic logic line_level(input logic active, input logic lvl);
    return lvl ? active : ~active;
  endfunction

  // Whether shared pin p carries line 2 for a given route code.
  function automatic logic pin_taken(input logic [1:0] route, input int p);
    return route == 2'(p + 1);
  endfunction
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status_i,
  output logic [N-1:0] change_o
);
  logic [N-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= status_i;
      primed_q <= 1'b1;
    end
  end

  // No change is reported until the history register holds a real sample.
  assign change_o = primed_q ? (status_i ^ prev_q) : '0;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] change_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           f_q <= 1'b0;
      else if (change_i[i]) f_q <= 1'b1;  // a new event wins over a clear
      else if (clr_i[i])    f_q <= 1'b0;
    end
    assign flags_o[i] = f_q;
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      mask1_o,
  output logic [N-1:0]      mask2_o,
  output cfg_t              cfg_o,
  output logic [N-1:0]      clr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask1_o <= '0;
      mask2_o <= '0;
      cfg_o   <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_MASK1: mask1_o <= wdata_i;
        A_MASK2: mask2_o <= wdata_i;
        A_CFG:   cfg_o   <= cfg_t'(wdata_i[CFG_W-1:0]);
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && addr_i == A_FLAGS) ? wdata_i : '0;
endmodule

// File: rtl/irq_out_route.sv
module irq_out_route
  import irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]     flags_i,
  input  logic [N-1:0]     mask1_i,
  input  logic [N-1:0]     mask2_i,
  input  cfg_t             cfg_i,
  input  logic [NPINS-1:0] pin_func_i,
  output logic             int1_o,
  output logic             int2_o,
  output logic [NPINS-1:0] pin_o
);
  logic act1, act2;

  assign act1   = cfg_i.en1 & (|(flags_i & mask1_i));
  assign act2   = cfg_i.en2 & (|(flags_i & mask2_i));
  assign int1_o = line_level(act1, cfg_i.lvl1);
  assign int2_o = line_level(act2, cfg_i.lvl2);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign pin_o[p] = pin_taken(cfg_i.route, p) ? int2_o : pin_func_i[p];
  end
endmodule

// File: rtl/irq_change_ctrl.sv
module irq_change_ctrl
  import irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      status_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N-1:0]      reg_wdata,
  output logic [N-1:0]      reg_rdata,
  output logic              int1_o,
  input  logic [NPINS-1:0]  pin_func_i,
  output logic [NPINS-1:0]  pin_o
);
  logic [N-1:0] change_w;
  logic [N-1:0] clr_w;
  logic [N-1:0] flags_q;
  logic [N-1:0] mask1_q;
  logic [N-1:0] mask2_q;
  cfg_t         cfg_q;
  logic         int2_w;

  irq_edge_detect #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .change_o(change_w)
  );

  irq_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .mask1_o(mask1_q), .mask2_o(mask2_q),
    .cfg_o(cfg_q), .clr_o(clr_w)
  );

  irq_flag_bank #(.N(N)) u_flags (
    .clk(clk), .rst_n(rst_n), .change_i(change_w), .clr_i(clr_w),
    .flags_o(flags_q)
  );

  irq_out_route #(.N(N)) u_route (
    .flags_i(flags_q), .mask1_i(mask1_q), .mask2_i(mask2_q), .cfg_i(cfg_q),
    .pin_func_i(pin_func_i), .int1_o(int1_o), .int2_o(int2_w), .pin_o(pin_o)
  );

  always_comb begin
    case (reg_addr)
      A_FLAGS: reg_rdata = flags_q;
      A_MASK1: reg_rdata = mask1_q;
      A_MASK2: reg_rdata = mask2_q;
      default: reg_rdata = {{(N-CFG_W){1'b0}}, cfg_q};
    endcase
  end
endmodule

// File: rtl/irq_change_ctrl_chk.sv
module irq_change_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] change_w,
  input logic [N-1:0] clr_w,
  input logic [N-1:0] flags_q,
  input logic [N-1:0] mask1_q,
  input logic [5:0]   cfg_bits,
  input logic         int1_o,
  input logic [2:0]   pin_func_i,
  input logic [2:0]   pin_o
);
  // R2 and R4: every reported change is latched, even under a same-cycle clear
  p_change_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (change_w != '0) |=> ((flags_q & $past(change_w)) == $past(change_w)));

  p_no_spurious_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(change_w)) == '0));

  p_clear_effect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_w & ~change_w) != '0) |=> ((flags_q & $past(clr_w & ~change_w)) == '0));

  p_int1_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bits[0] && (flags_q & mask1_q) != '0) |-> (int1_o == cfg_bits[1]));

  p_int1_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & mask1_q) == '0) |-> (int1_o == !cfg_bits[1]));

  p_int1_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_bits[0]) |-> (int1_o == !cfg_bits[1]));

  p_route_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bits[5:4] == 2'd0) |-> (pin_o == pin_func_i));
endmodule

bind irq_change_ctrl irq_change_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .change_w(change_w), .clr_w(clr_w),
  .flags_q(flags_q), .mask1_q(mask1_q), .cfg_bits(cfg_q),
  .int1_o(int1_o), .pin_func_i(pin_func_i), .pin_o(pin_o)
);

// File: tb/irq_change_ctrl_bench.sv
module irq_change_ctrl_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] status_i = '0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         int1_o;
  logic [2:0]   pin_func_i = '0;
  logic [2:0]   pin_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  irq_change_ctrl #(.N(N)) u_irq_change_ctrl (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int1_o(int1_o), .pin_func_i(pin_func_i), .pin_o(pin_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic lvl(input logic en, input logic pol, input logic [N-1:0] f,
                               input logic [N-1:0] m);
    logic act;
    act = en && ((f & m) != 0);
    return (act == pol);
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [N-1:0] d;
    logic [N-1:0] fl [4];
    logic [N-1:0] m1 [3];
    logic [N-1:0] m2 [3];
    fl[0] = 8'h00; fl[1] = 8'h01; fl[2] = 8'h80; fl[3] = 8'h3C;
    m1[0] = 8'hFF; m1[1] = 8'h0F; m1[2] = 8'h81;
    m2[0] = 8'h00; m2[1] = 8'hF0; m2[2] = 8'h3C;

    // R1 / R2: nonzero status held across reset must not flag
    status_i = 8'hA5;
    pin_func_i = 3'b101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(0, d); check("R1/R2 flags after reset", d, 0);
    rd(1, d); check("R1 mask1 reset", d, 0);
    rd(2, d); check("R1 mask2 reset", d, 0);
    rd(3, d); check("R1 cfg reset", d, 0);
    check("R1 int1 idle", int1_o, 1);
    check("R1 pins pass", pin_o, 3'b101);
    @(negedge clk);

    // R2 / R3: every bit, both directions
    for (int i = 0; i < N; i++) begin
      for (int dir = 0; dir < 2; dir++) begin
        status_i[i] = ~status_i[i];
        @(negedge clk);
        rd(0, d); check("R2 toggle sets flag", d, 1 << i);
        wr(0, ~(8'(1) << i));
        rd(0, d); check("R3 zero bits keep flag", d, 1 << i);
        wr(0, 8'(1) << i);
        rd(0, d); check("R3 one clears flag", d, 0);
      end
    end

    // R4: change concurrent with clear keeps flag
    status_i[3] = ~status_i[3];
    @(negedge clk);
    status_i[3] = ~status_i[3];
    wr(0, 8'h08);
    rd(0, d); check("R4 change beats clear", d, 8'h08);
    wr(0, 8'hFF);
    rd(0, d); check("R4 later clear works", d, 0);

    // R5..R8: enable/level sweep, line 2 observed on pin 0
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 4; f++) begin
        for (int m = 0; m < 3; m++) begin
          wr(3, 8'(c | 8'h10));
          wr(1, m1[m]);
          wr(2, m2[m]);
          wr(0, 8'hFF);
          status_i = status_i ^ fl[f];
          @(negedge clk);
          check(c[0] ? "R5/R7 int1 level" : "R8 int1 disabled", int1_o,
                lvl(c[0], c[1], fl[f], m1[m]));
          check(c[2] ? "R6/R7 int2 level" : "R8 int2 disabled", pin_o[0],
                lvl(c[2], c[3], fl[f], m2[m]));
        end
      end
    end

    // R9: route sweep with line 2 at both levels
    wr(0, 8'hFF);
    wr(2, 8'h01);
    for (int lv = 0; lv < 2; lv++) begin
      if (lv == 1) begin
        status_i[0] = ~status_i[0];
        @(negedge clk);
      end
      for (int r = 0; r < 4; r++) begin
        wr(3, 8'(8'h0C | (r << 4)));
        for (int p = 0; p < 8; p++) begin
          logic [2:0] e;
          pin_func_i = 3'(p);
          #1;
          e = 3'(p);
          if (r != 0) e[r-1] = 1'(lv);
          check("R9 pin routing", pin_o, e);
        end
        @(negedge clk);
      end
    end

    // R10: readback
    wr(1, 8'h5A); rd(1, d); check("R10 mask1 readback", d, 8'h5A);
    wr(2, 8'hC3); rd(2, d); check("R10 mask2 readback", d, 8'hC3);
    wr(3, 8'hFF); rd(3, d); check("R10 cfg readback", d, 8'h3F);
    rd(1, d); check("R10 mask1 kept", d, 8'h5A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule